// File: doc/BRIEF.md
# I2C Target Byte Engine

This block lets a chip answer on a two-wire I2C bus as a target with a 7-bit address. SCL and SDA are brought in through two-flop synchronisers onto the system clock. The block watches for START and STOP and shifts bytes in and out MSb first. It acknowledges the bytes addressed to it, and it holds SCL low during reads until local software has supplied the next byte. On the bus side it has only two open-drain pull-down enables, one for each line.

Software reaches the block through four byte-wide registers. They hold a single transfer byte, status flags, control and sticky error flags, and the target address. A level interrupt rises at the end of every byte event in which the block takes part. Software then reads the status to work out what happened. It either takes the received byte or loads the next byte to send, and sets the release bit to let SCL go.

Top module: `i2c_tgt_core`

## Requirements
- R1: SDA falling while SCL is high is a START; SDA rising while SCL is high is a STOP. STATUS bit 2 (start seen) and bit 3 (stop seen) show which of the two came last. Both read 0 after reset and while the block is disabled.
- R2: The address byte's upper seven bits are compared with ADDR bits 7:1. On a match the block pulls SDA low during the ninth clock. On a mismatch it never drives SDA and ignores all bytes until the next START or STOP.
- R3: Bit 0 of a matching address byte is captured in STATUS bit 1 (1 = read). A read-address byte sets the event flag and clears STATUS bit 4, but leaves STATUS bit 0 (buffer full) unchanged.
- R4: A matching write-address byte, and every byte received after it, is copied into DATA, sets buffer full, sets the event flag (CTRL bit 0, also driven on the irq output) and is acknowledged. STATUS bit 4 reads 0 after an address byte and 1 after a data byte.
- R5: A byte that completes while buffer full is set sets CTRL bit 1 (overflow), leaves DATA unchanged and is not acknowledged. While overflow stays set, later bytes are still loaded but not acknowledged, even once the buffer has been read.
- R6: After a read-address byte is acknowledged, and after each sent byte that the master acknowledges, CTRL bit 3 (release) is cleared on the ninth SCL fall and SCL is held low. Writing 1 to CTRL bit 3 releases it; writing 0 to that bit has no effect.
- R7: In transmit, a DATA write loads the byte and sets buffer full. The byte goes out MSb first, and buffer full clears once its eighth bit has been clocked out. DATA writes outside transmit are ignored.
- R8: A DATA write while buffer full is still set in transmit sets CTRL bit 2 (write collision) and leaves the byte being sent unchanged.
- R9: A master NACK on a sent byte sets the event flag and STATUS bit 4 and clears STATUS bit 1. The block then neither drives nor holds the bus until the next START.
- R10: A START that arrives without a STOP before it begins a new address phase and clears the read/write flag.
- R11: The block changes its SDA drive only while the synchronised SCL is low.
- R12: Register select 0 = DATA, 1 = STATUS (read only), 2 = CTRL, 3 = ADDR. CTRL bit 4 is enable. CTRL bits 0 to 2 are cleared by writing 1 and are otherwise set only by hardware. Reading DATA clears buffer full. After reset STATUS reads 0x00 and CTRL reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_sel | input | 2 | Register select |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects on DATA) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Event flag |

## Verification
The main function is driven with several kinds of address byte: a matching write address, a matching read address, a foreign address followed by more clocking, and a read address reached through a repeated START. Comparing the acknowledge bit and STATUS across these separates the match, direction and ignore paths. Received data runs through three cases: the buffer empty, the buffer still full, and the buffer read but the overflow flag not yet cleared. These separate plain loading, overflow, and the sticky NACK. In transmit the bench reads back known bytes with the master acknowledging and then not acknowledging, and makes a second host write during shifting. This shows the stretch points, MSb-first order, write collision and return to idle.

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [1:0] host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq
);

  typedef enum logic [1:0] {M_IDLE, M_ADDR, M_RX, M_TX} mode_t;
  localparam logic [1:0] SEL_DATA = 2'd0, SEL_STAT = 2'd1, SEL_CTRL = 2'd2, SEL_ADR = 2'd3;

  mode_t       mode;
  logic [2:0]  scl_p, sda_p;
  logic [3:0]  bit_cnt;
  logic [7:0]  sh, hbuf;
  logic [6:0]  adr_q;
  logic        full_q, rw_q, st_q, sp_q, dat_q, evt_q, ovf_q, wcol_q, rel_q, en_q;
  logic        ack_pend, ack_oe, tx_oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end

  wire scl_s = scl_p[1];
  wire scl_d = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_d = sda_p[2];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire bus_start = en_q & scl_s & scl_d & sda_d & ~sda_s;
  wire bus_stop  = en_q & scl_s & scl_d & ~sda_d & sda_s;

  wire [7:0] rx_byte = {sh[6:0], sda_s};
  wire adr_hit = (rx_byte[7:1] == adr_q);
  wire rx_bit7 = en_q & scl_rise & (bit_cnt == 4'd7) & (mode == M_ADDR || mode == M_RX);
  wire wr_byte_end = rx_bit7 & (mode == M_RX || (adr_hit & ~rx_byte[0]));
  wire rd_addr_end = rx_bit7 & (mode == M_ADDR) & adr_hit & rx_byte[0];

  wire wr_data = host_wr & (host_sel == SEL_DATA);
  wire rd_data = host_rd & (host_sel == SEL_DATA);
  wire wr_ctrl = host_wr & (host_sel == SEL_CTRL);
  wire wr_adr  = host_wr & (host_sel == SEL_ADR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_IDLE;
      bit_cnt <= '0;
      sh <= '0;
      hbuf <= '0;
      adr_q <= '0;
      {full_q, rw_q, st_q, sp_q, dat_q, evt_q, ovf_q, wcol_q, en_q} <= '0;
      rel_q <= 1'b1;
      {ack_pend, ack_oe, tx_oe} <= '0;
    end else begin
      // host side
      if (wr_data && mode == M_TX) begin
        if (full_q) wcol_q <= 1'b1;
        else begin
          hbuf <= host_wdata;
          sh <= host_wdata;
          full_q <= 1'b1;
          if (bit_cnt == 4'd0 && !scl_s) tx_oe <= ~host_wdata[7];
        end
      end
      if (rd_data) full_q <= 1'b0;
      if (wr_ctrl) begin
        if (host_wdata[0]) evt_q <= 1'b0;
        if (host_wdata[1]) ovf_q <= 1'b0;
        if (host_wdata[2]) wcol_q <= 1'b0;
        if (host_wdata[3]) rel_q <= 1'b1;
        en_q <= host_wdata[4];
      end
      if (wr_adr) adr_q <= host_wdata[7:1];

      // bus side, takes priority over host
      if (!en_q) begin
        mode <= M_IDLE;
        bit_cnt <= '0;
        {rw_q, st_q, sp_q, ack_oe, tx_oe} <= '0;
      end else if (bus_start) begin
        mode <= M_ADDR;
        bit_cnt <= '0;
        rw_q <= 1'b0;
        st_q <= 1'b1;
        sp_q <= 1'b0;
        ack_oe <= 1'b0;
        tx_oe <= 1'b0;
      end else if (bus_stop) begin
        mode <= M_IDLE;
        rw_q <= 1'b0;
        st_q <= 1'b0;
        sp_q <= 1'b1;
        ack_oe <= 1'b0;
        tx_oe <= 1'b0;
      end else if (scl_rise) begin
        if (mode != M_IDLE && bit_cnt != 4'd9) bit_cnt <= bit_cnt + 4'd1;
        if ((mode == M_ADDR || mode == M_RX) && bit_cnt < 4'd8) sh <= rx_byte;
        if (mode == M_ADDR && bit_cnt == 4'd7 && !adr_hit) mode <= M_IDLE;
        if (rd_addr_end) begin
          rw_q <= 1'b1;
          dat_q <= 1'b0;
          evt_q <= 1'b1;
          ack_pend <= 1'b1;
        end
        if (wr_byte_end) begin
          evt_q <= 1'b1;
          dat_q <= (mode == M_RX);
          if (mode == M_ADDR) rw_q <= 1'b0;
          if (full_q) begin
            ovf_q <= 1'b1;
            ack_pend <= 1'b0;
          end else begin
            hbuf <= rx_byte;
            full_q <= 1'b1;
            ack_pend <= ~ovf_q;
          end
        end
        if (mode == M_TX && bit_cnt == 4'd7) full_q <= 1'b0;
        if (mode == M_TX && bit_cnt == 4'd8) begin
          evt_q <= 1'b1;
          dat_q <= 1'b1;
          if (sda_s) begin
            mode <= M_IDLE;
            rw_q <= 1'b0;
          end
        end
      end else if (scl_fall) begin
        if (mode == M_ADDR || mode == M_RX) begin
          if (bit_cnt == 4'd8) ack_oe <= ack_pend;
          if (bit_cnt == 4'd9) begin
            ack_oe <= 1'b0;
            bit_cnt <= '0;
            if (mode == M_ADDR) begin
              if (rw_q) begin
                mode <= M_TX;
                rel_q <= 1'b0;
                tx_oe <= 1'b0;
              end else mode <= M_RX;
            end
          end
        end else if (mode == M_TX) begin
          if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
            sh <= {sh[6:0], 1'b0};
            tx_oe <= ~sh[6];
          end
          if (bit_cnt == 4'd8) tx_oe <= 1'b0;
          if (bit_cnt == 4'd9) begin
            bit_cnt <= '0;
            rel_q <= 1'b0;
            tx_oe <= full_q & ~sh[7];
          end
        end
      end
    end

  assign sda_oe = ack_oe | tx_oe;
  assign scl_oe = en_q & (mode == M_TX) & ~rel_q;
  assign irq = evt_q;

  always_comb
    case (host_sel)
      SEL_DATA: host_rdata = hbuf;
      SEL_STAT: host_rdata = {3'b000, dat_q, sp_q, st_q, rw_q, full_q};
      SEL_CTRL: host_rdata = {3'b000, en_q, rel_q, wcol_q, ovf_q, evt_q};
      default:  host_rdata = {adr_q, 1'b0};
    endcase

  a_r1_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q && sp_q));

  a_r3_rdaddr_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_end && !rd_data) |=> $stable(full_q));

  a_r5_no_overflow_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_end && full_q) |=> (ovf_q && $stable(hbuf)));

  a_r6_stretch_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_s));

  a_r8_wcol_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && mode == M_TX && full_q) |=> (wcol_q && $stable(hbuf)));

  a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(bus_start || bus_stop || !en_q)));

endmodule

// File: tb/i2c_tgt_core_tb_top.sv
module i2c_tgt_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe;
  logic [1:0] host_sel = 2'd0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic irq;

  i2c_tgt_core dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq));

  localparam int Q = 10;
  int n_chk = 0, n_bad = 0, edge_viol = 0;
  logic prev_oe = 1'b0;
  logic sda_seen = 1'b0;

  always @(negedge clk) begin
    if (sda_oe !== prev_oe && scl_bus) edge_viol++;
    prev_oe = sda_oe;
    if (sda_oe) sda_seen = 1'b1;
  end

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic scl_high();
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_bus);
  endtask

  task automatic mbit_out(input logic b);
    sda_m = b; waitq();
    scl_high(); waitq(); waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic mbit_in(output logic b);
    sda_m = 1'b1; waitq();
    scl_high(); waitq();
    b = sda_bus; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic msend(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) mbit_out(v[i]);
    mbit_in(b);
    acked = ~b;
  endtask

  task automatic mrecv(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) mbit_in(v[i]);
    mbit_out(~ack);
  endtask

  task automatic mstart();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic mstop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    hread(2'd1, d); check(d, 8'h00, "R12 status after reset");
    hread(2'd2, d); check(d, 8'h08, "R12 ctrl after reset");
    check({7'd0, sda_oe | scl_oe}, 8'h00, "R12 lines released after reset");
    hwrite(2'd3, 8'hA0);
    hwrite(2'd2, 8'h10);
    hread(2'd3, d); check(d, 8'hA0, "R12 address readback");
  endtask

  task automatic t_write();
    logic [7:0] d; logic a;
    mstart();
    hread(2'd1, d); check(d & 8'h0C, 8'h04, "R1 start seen");
    msend(8'hA0, a); check({7'd0, a}, 8'h01, "R2 matching address acked");
    hread(2'd1, d); check(d, 8'h05, "R4 status after write address");
    check({7'd0, irq}, 8'h01, "R4 irq after address");
    hread(2'd0, d); check(d, 8'hA0, "R4 address byte in data");
    hwrite(2'd2, 8'h11);
    hwrite(2'd0, 8'hEE);
    hread(2'd0, d); check(d, 8'hA0, "R7 data write outside transmit ignored");
    hread(2'd1, d); check(d & 8'h01, 8'h00, "R7 ignored write leaves buffer empty");
    msend(8'h3C, a); check({7'd0, a}, 8'h01, "R4 data byte acked");
    hread(2'd1, d); check(d, 8'h15, "R4 status after data byte");
    hread(2'd0, d); check(d, 8'h3C, "R4 data byte received");
  endtask

  task automatic t_overflow();
    logic [7:0] d; logic a;
    msend(8'h11, a); check({7'd0, a}, 8'h01, "R5 byte before overflow acked");
    msend(8'h22, a); check({7'd0, a}, 8'h00, "R5 overflow byte nacked");
    hread(2'd2, d); check(d & 8'h02, 8'h02, "R5 overflow flag set");
    hread(2'd0, d); check(d, 8'h11, "R5 buffer kept old byte");
    msend(8'h33, a); check({7'd0, a}, 8'h00, "R5 nack persists until flag cleared");
    hread(2'd0, d); check(d, 8'h33, "R5 byte loaded while flag set");
    hwrite(2'd2, 8'h13);
    msend(8'h44, a); check({7'd0, a}, 8'h01, "R5 ack after flag cleared");
    hread(2'd0, d); check(d, 8'h44, "R5 data after recovery");
    mstop();
    hread(2'd1, d); check(d, 8'h18, "R1 stop seen, start clear");
  endtask

  task automatic t_mismatch();
    logic [7:0] d; logic a;
    hwrite(2'd2, 8'h11);
    sda_seen = 1'b0;
    mstart();
    msend(8'hB0, a); check({7'd0, a}, 8'h00, "R2 foreign address nacked");
    msend(8'h55, a); check({7'd0, a}, 8'h00, "R2 later byte ignored");
    check({7'd0, sda_seen}, 8'h00, "R2 sda never driven on mismatch");
    hread(2'd1, d); check(d, 8'h14, "R2 status untouched by foreign bytes");
    hread(2'd2, d); check(d & 8'h01, 8'h00, "R2 no event on mismatch");
    mstop();
  endtask

  task automatic t_read();
    logic [7:0] d, b1, b2, b3; logic a;
    hwrite(2'd2, 8'h11);
    mstart();
    msend(8'hA1, a); check({7'd0, a}, 8'h01, "R2 read address acked");
    hread(2'd1, d); check(d, 8'h06, "R3 status after read address");
    check({7'd0, scl_oe}, 8'h01, "R6 scl held after read address");
    fork
      mrecv(b1, 1'b1);
      begin
        repeat (50) @(negedge clk);
        check({7'd0, scl_bus}, 8'h00, "R6 clock stretched until release");
        hwrite(2'd0, 8'h5A);
        hread(2'd1, d); check(d & 8'h01, 8'h01, "R7 host write sets full");
        hwrite(2'd2, 8'h18);
      end
    join
    check(b1, 8'h5A, "R7 first byte sent msb first");
    check({7'd0, scl_oe}, 8'h01, "R6 scl held after master ack");
    hread(2'd2, d); check(d & 8'h08, 8'h00, "R6 release bit cleared");
    hread(2'd1, d); check(d, 8'h16, "R7 status after sent byte");
    fork
      mrecv(b2, 1'b0);
      begin
        hwrite(2'd0, 8'hC3);
        hwrite(2'd2, 8'h18);
        repeat (100) @(negedge clk);
        hwrite(2'd0, 8'hFF);
        hread(2'd2, d); check(d & 8'h04, 8'h04, "R8 write collision flagged");
      end
    join
    check(b2, 8'hC3, "R8 byte unchanged by collision");
    hread(2'd1, d); check(d, 8'h14, "R9 status after master nack");
    check({7'd0, scl_oe}, 8'h00, "R9 no stretch after nack");
    sda_seen = 1'b0;
    mrecv(b3, 1'b0);
    check(b3, 8'hFF, "R9 bus left alone after nack");
    check({7'd0, sda_seen}, 8'h00, "R9 sda not driven after nack");
    hwrite(2'd2, 8'h15);
    mstop();
  endtask

  task automatic t_restart();
    logic [7:0] d, b; logic a;
    mstart();
    msend(8'hA0, a);
    hread(2'd0, d);
    msend(8'h01, a); check({7'd0, a}, 8'h01, "R10 data before restart acked");
    hread(2'd1, d); check(d, 8'h15, "R10 status before restart");
    hread(2'd0, d);
    mstart();
    msend(8'hA1, a); check({7'd0, a}, 8'h01, "R10 address after restart acked");
    hread(2'd1, d); check(d, 8'h06, "R10 new address phase, read direction");
    fork
      mrecv(b, 1'b0);
      begin
        repeat (20) @(negedge clk);
        hwrite(2'd0, 8'h99);
        hwrite(2'd2, 8'h18);
      end
    join
    check(b, 8'h99, "R10 byte read after restart");
    mstop();
    hread(2'd1, d); check(d, 8'h18, "R9 rw cleared then stop");
  endtask

  task automatic t_disable();
    logic [7:0] d;
    hwrite(2'd2, 8'h00);
    hread(2'd1, d); check(d & 8'h0C, 8'h00, "R1 start and stop clear when disabled");
    hwrite(2'd2, 8'h10);
    check(edge_viol[7:0], 8'h00, "R11 sda changed only with scl low");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_overflow();
    t_mismatch();
    t_read();
    t_restart();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule